// File: doc/BRIEF.md
# Serial Column Mixer for a Block Cipher Round

This block performs the column-mixing step of a 128-bit block cipher round, in either the forward or the inverse direction. The four bytes of one state column enter one per accepted clock from the substitution stage. The block presents all four mixed bytes together once the fourth byte has been taken. Each arriving byte is multiplied in GF(2^8) by the four matrix coefficients, using the reduction polynomial x^8+x^4+x^3+x+1. The products are XORed into four 8-bit accumulators. Each accumulator receives the coefficient that matches its distance from the byte's position in the column.

The inverse coefficients are not built separately. Each one is a forward coefficient XORed with 08 or 0C. As a result, the only multipliers added for the inverse are multiply-by-08 and multiply-by-0C. The direction is taken from the select input when a column's first byte arrives, and it is held for the rest of that column.

Top module: `mixcol_serial`

## Requirements
- R1: After reset, `out_valid` is 0 and all four result bytes are 00.
- R2: With `inv_sel` low at the first byte, the block computes out_i = XOR over j of c[(j-i) mod 4]·a_j. Here a_0..a_3 are the accepted bytes in arrival order, c = {02,03,01,01}, and out_i is driven on `col_out<i>`. For example, db,13,53,45 gives 8e,4d,a1,bc.
- R3: With `inv_sel` high at the first byte, the same formula is used with c = {0E,0B,0D,09}.
- R4: A change of `inv_sel` after a column's first byte has been accepted has no effect on that column's result.
- R5: `out_valid` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the fourth byte of a column.
- R6: A cycle with `in_valid` low neither advances the byte position nor changes the result bytes.
- R7: A result stays on the outputs until the first byte of the next column is accepted. That byte may arrive in the same cycle that `out_valid` is high.
- R8: Feeding the result of a forward column back as an inverse column returns the original four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Column byte, first byte of the column first |
| inv_sel | input | 1 | 1 selects the inverse mix; sampled with a column's first byte |
| col_out0 | output | 8 | Result byte 0 |
| col_out1 | output | 8 | Result byte 1 |
| col_out2 | output | 8 | Result byte 2 |
| col_out3 | output | 8 | Result byte 3 |
| out_valid | output | 1 | One-cycle strobe: result bytes are complete |

## Verification
Published known-answer columns are used in both directions. They separate a correct coefficient rotation from a transposed matrix, a wrong reduction constant or a swapped 08/0C term. Uniform columns such as 01,01,01,01 expose any coefficient set whose XOR sum is not 01. Random columns fed forward and then back through the inverse tie the two modes together. The bytes are streamed back-to-back, with idle gaps inside a column and with `inv_sel` toggled mid-column. These patterns show whether position, mode capture and result holding depend on `in_valid` alone.

// File: rtl/mixcol_serial.sv
module mixcol_serial (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       inv_sel,
  output logic [7:0] col_out0,
  output logic [7:0] col_out1,
  output logic [7:0] col_out2,
  output logic [7:0] col_out3,
  output logic       out_valid
);
  localparam int NB = 4;

  logic [1:0] pos;
  logic       mode_q;
  logic [7:0] acc [NB];
  logic [7:0] prod [NB];

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  wire       first = (pos == 2'd0);
  wire       mode  = first ? inv_sel : mode_q;
  wire [7:0] m1 = in_byte;
  wire [7:0] m2 = xt(m1);
  wire [7:0] m4 = xt(m2);
  wire [7:0] m8 = xt(m4);
  wire [7:0] m3 = m2 ^ m1;
  wire [7:0] mc = m8 ^ m4;

  assign prod[0] = m2 ^ (mode ? mc : 8'h00);
  assign prod[1] = m3 ^ (mode ? m8 : 8'h00);
  assign prod[2] = m1 ^ (mode ? mc : 8'h00);
  assign prod[3] = m1 ^ (mode ? m8 : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= 2'd0;
      mode_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && (pos == 2'd3);
      if (in_valid) begin
        pos <= pos + 2'd1;
        if (first) mode_q <= inv_sel;
      end
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_acc
    localparam logic [1:0] ROW = 2'(i);
    wire [1:0] k = pos - ROW;
    always_ff @(posedge clk) begin
      if (!rst_n) acc[i] <= 8'h00;
      else if (in_valid) acc[i] <= (first ? 8'h00 : acc[i]) ^ prod[k];
    end
  end

  assign col_out0 = acc[0];
  assign col_out1 = acc[1];
  assign col_out2 = acc[2];
  assign col_out3 = acc[3];

  assert_strobe_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pos == 2'd3 |=> out_valid);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_idle_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(col_out0) && $stable(col_out1) && $stable(col_out2) && $stable(col_out3));
  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pos != 2'd0 |=> $stable(mode_q));
endmodule

// File: tb/mixcol_serial_test.sv
module mixcol_serial_test;
  logic clk = 0, rst_n = 0, in_valid = 0, inv_sel = 0;
  logic [7:0] in_byte = 0;
  logic [7:0] o0, o1, o2, o3;
  logic ov;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mixcol_serial uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .inv_sel(inv_sel), .col_out0(o0), .col_out1(o1), .col_out2(o2), .col_out3(o3),
    .out_valid(ov));

  int cnt = 0; bit mmode = 0; bit exp_v = 0; bit held = 0;
  logic [7:0] q [4]; logic [7:0] res [4];

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a;
    for (int n = 0; n < 8; n++) begin
      if (b[n]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input logic [7:0] b, input bit m);
    logic [7:0] cf [4];
    in_valid = v; in_byte = b; inv_sel = m;
    @(posedge clk); #1;
    exp_v = 0;
    if (v) begin
      if (cnt == 0) mmode = m;
      q[cnt] = b; cnt++; held = 0;
      if (cnt == 4) begin
        if (mmode) cf = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
        else       cf = '{8'h02, 8'h03, 8'h01, 8'h01};
        for (int i = 0; i < 4; i++) begin
          res[i] = 0;
          for (int j = 0; j < 4; j++) res[i] ^= gmul(q[j], cf[(j - i + 4) % 4]);
        end
        cnt = 0; exp_v = 1; held = 1;
      end
    end
    check("R5 out_valid", {31'd0, ov}, {31'd0, exp_v});
    if (held)
      check(exp_v ? (mmode ? "R3 inverse result" : "R2 forward result") : "R7/R6 held result",
            {o0, o1, o2, o3}, {res[0], res[1], res[2], res[3]});
  endtask

  task automatic column(input logic [31:0] col, input bit m, input bit gaps, input bit toggle,
                        output logic [31:0] outv);
    for (int j = 0; j < 4; j++) begin
      if (gaps && j == 2) begin cycle(0, 8'hee, ~m); cycle(0, 8'h5a, m); end
      cycle(1, col[31 - 8*j -: 8], (toggle && j > 0) ? ~m : m);
    end
    outv = {o0, o1, o2, o3};
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2, c;
    @(posedge clk); #1; @(posedge clk); #1;
    check("R1 reset out_valid", {31'd0, ov}, 0);
    check("R1 reset outputs", {o0, o1, o2, o3}, 0);
    rst_n = 1;
    cycle(0, 0, 0);
    column(32'hdb135345, 0, 0, 0, r);  check("R2 kat1", r, 32'h8e4da1bc);
    column(32'hf20a225c, 0, 0, 0, r);  check("R2 kat2", r, 32'h9fdc589d);
    column(32'h01010101, 0, 0, 0, r);  check("R2 uniform", r, 32'h01010101);
    column(32'hd4d4d4d5, 0, 1, 0, r);  check("R6 gaps kat", r, 32'hd5d5d7d6);
    column(32'h8e4da1bc, 1, 0, 0, r);  check("R3 inverse kat", r, 32'hdb135345);
    column(32'hc6c6c6c6, 1, 0, 0, r);  check("R3 uniform", r, 32'hc6c6c6c6);
    column(32'hdb135345, 0, 0, 1, r);  check("R4 toggle fwd", r, 32'h8e4da1bc);
    column(32'h9fdc589d, 1, 1, 1, r);  check("R4 toggle inv", r, 32'hf20a225c);
    repeat (3) cycle(0, 8'h77, 1);
    check("R7 hold", {o0, o1, o2, o3}, 32'hf20a225c);
    for (int t = 0; t < 40; t++) begin
      c = $urandom;
      column(c, 0, t[0], 0, r);
      column(r, 1, t[1], 0, r2);
      check("R8 roundtrip", r2, c);
    end
    cycle(0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule